// File: doc/BRIEF.md
# Counter Read Permission Checker

This block decides, in a single combinational step, whether an instruction that reads one of the user-level counter registers may proceed. The register address is decoded into a counter index. That index selects one bit in a mask of implemented counters and one bit in each of the three counter-enable words: machine, hypervisor and supervisor. The current privilege level and the virtualization flag then decide which of those bits matter.

The result is one of three verdicts. The read is allowed, it raises an illegal-instruction fault, or it raises a virtual-instruction fault. The surrounding register file uses the verdict to either return data or raise the matching trap. The block does not produce the counter value itself.

The counter window holds 32 entries. Index 0 is the cycle counter, index 1 the real-time counter, index 2 the retired-instruction counter, and indices 3 to 31 the event counters. The low halves sit at 0xC00 to 0xC1F. The upper halves sit at 0xC80 to 0xC9F and exist only when the core runs 32-bit registers.

Top module: `ctr_perm_chk`

## Requirements
- R1: An address 0xC00+i selects counter i. When `xlen32_i` is 1, the address 0xC80+i also selects counter i and gives the same verdict as 0xC00+i under the same inputs.
- R2: An address outside 0xC00..0xC1F and 0xC80..0xC9F gives the illegal verdict. An address in 0xC80..0xC9F also gives the illegal verdict when `xlen32_i` is 0.
- R3: Counters 0, 1 and 2 bypass the implemented-counter mask. In machine mode they are allowed even when `avail_mask_i` is all zeros.
- R4: A counter with index 3 or more whose bit in `avail_mask_i` is 0 gives the illegal verdict in every privilege mode. With the mask all zeros, every such counter is illegal.
- R5: In machine mode (`priv_i` = 2'b11), every decoded address that passes the mask check is allowed, whatever the enable words and `virt_i` hold.
- R6: In supervisor mode with `virt_i` = 0, the verdict is illegal when the counter's bit in `men_i` is 0, and allowed otherwise.
- R7: In user mode (`priv_i` = 2'b00) with `virt_i` = 0, the read is allowed only when the counter's bits in both `men_i` and `sen_i` are 1. Otherwise it is illegal.
- R8: In virtualized supervisor mode, a clear `men_i` bit gives illegal. A set `men_i` bit with a clear `hen_i` bit gives virtual. Both bits set gives allow.
- R9: In virtualized user mode, a clear `men_i` bit gives illegal. A set `men_i` bit with a clear `hen_i` or `sen_i` bit gives virtual. All three bits set gives allow.
- R10: The verdict encoding is 2'b00 allow, 2'b01 illegal, 2'b10 virtual, and 2'b11 never appears. The illegal verdict takes priority over the virtual verdict. The reserved privilege code 2'b10 always gives illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| csr_addr_i | input | 12 | Address of the register being read |
| priv_i | input | 2 | Privilege level: 00 user, 01 supervisor, 11 machine, 10 reserved |
| virt_i | input | 1 | Hart runs in a virtualized guest |
| xlen32_i | input | 1 | Core runs 32-bit registers |
| avail_mask_i | input | 32 | One bit per implemented counter |
| men_i | input | 32 | Machine-level counter enables |
| hen_i | input | 32 | Hypervisor-level counter enables |
| sen_i | input | 32 | Supervisor-level counter enables |
| verdict_o | output | 2 | 00 allow, 01 illegal-instruction, 10 virtual-instruction |

## Verification
The bench builds the checker with its default 32-entry window and a 12-bit address. That lets random addresses hit the fixed counters, the event counters, both halves, and the gaps just outside each window. Enable and mask words are drawn with a bias toward set bits, so the chained conditions for virtual-mode user reads are regularly satisfied or broken one bit at a time. Directed cases cover the empty mask, the half-to-half equivalence, the reserved privilege code, and a mask miss that lands on a virtual-mode condition.

// File: rtl/ctr_perm_pkg.sv
package ctr_perm_pkg;

    localparam int CSR_AW     = 12;
    localparam int CTR_NUM    = 32;
    localparam int IDX_W      = $clog2(CTR_NUM);
    localparam int FIXED_LAST = 2;

    localparam logic [CSR_AW-1:0] LO_BASE = 12'hC00;
    localparam logic [CSR_AW-1:0] HI_BASE = 12'hC80;
    localparam logic [CSR_AW-1:0] LO_END  = LO_BASE + CSR_AW'(CTR_NUM);
    localparam logic [CSR_AW-1:0] HI_END  = HI_BASE + CSR_AW'(CTR_NUM);

    typedef enum logic [1:0] {
        PRV_USER  = 2'b00,
        PRV_SUPER = 2'b01,
        PRV_RSVD  = 2'b10,
        PRV_MACH  = 2'b11
    } priv_e;

    typedef enum logic [1:0] {
        VERD_ALLOW   = 2'b00,
        VERD_ILLEGAL = 2'b01,
        VERD_VIRTUAL = 2'b10
    } verdict_e;

    typedef struct packed {
        logic             hit;
        logic             high;
        logic             fixed;
        logic [IDX_W-1:0] idx;
    } ctr_sel_t;

    typedef struct packed {
        logic m;
        logic h;
        logic s;
    } en_bits_t;

    function automatic logic in_window(logic [CSR_AW-1:0] a,
                                       logic [CSR_AW-1:0] lo,
                                       logic [CSR_AW-1:0] hi);
        return (a >= lo) && (a < hi);
    endfunction

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
    import ctr_perm_pkg::*;
(
    input  logic [CSR_AW-1:0] addr_i,
    input  logic              xlen32_i,
    output ctr_sel_t          sel_o
);
    logic              lo_hit, hi_hit;
    logic [CSR_AW-1:0] lo_off, hi_off;

    always_comb begin
        lo_hit = in_window(addr_i, LO_BASE, LO_END);
        hi_hit = in_window(addr_i, HI_BASE, HI_END);
        lo_off = addr_i - LO_BASE;
        hi_off = addr_i - HI_BASE;

        sel_o.hit   = lo_hit | (hi_hit & xlen32_i);
        sel_o.high  = hi_hit;
        sel_o.idx   = hi_hit ? hi_off[IDX_W-1:0] : lo_off[IDX_W-1:0];
        sel_o.fixed = (int'(sel_o.idx) <= FIXED_LAST);
    end
endmodule

// File: rtl/ctr_avail_gate.sv
module ctr_avail_gate
    import ctr_perm_pkg::*;
(
    input  ctr_sel_t           sel_i,
    input  logic [CTR_NUM-1:0] avail_mask_i,
    output logic               pass_o
);
    always_comb begin
        pass_o = sel_i.hit && (sel_i.fixed || avail_mask_i[sel_i.idx]);
    end
endmodule

// File: rtl/ctr_priv_gate.sv
module ctr_priv_gate
    import ctr_perm_pkg::*;
(
    input  priv_e    priv_i,
    input  logic     virt_i,
    input  en_bits_t en_i,
    output verdict_e verdict_o
);
    always_comb begin
        verdict_o = VERD_ILLEGAL;
        unique case (priv_i)
            PRV_MACH: verdict_o = VERD_ALLOW;
            PRV_SUPER: begin
                if (!en_i.m)                verdict_o = VERD_ILLEGAL;
                else if (virt_i && !en_i.h) verdict_o = VERD_VIRTUAL;
                else                        verdict_o = VERD_ALLOW;
            end
            PRV_USER: begin
                if (!virt_i)
                    verdict_o = (en_i.m && en_i.s) ? VERD_ALLOW : VERD_ILLEGAL;
                else if (!en_i.m)
                    verdict_o = VERD_ILLEGAL;
                else if (!en_i.h || !en_i.s)
                    verdict_o = VERD_VIRTUAL;
                else
                    verdict_o = VERD_ALLOW;
            end
            default: verdict_o = VERD_ILLEGAL;
        endcase
    end
endmodule

// File: rtl/ctr_perm_chk.sv
module ctr_perm_chk
    import ctr_perm_pkg::*;
(
    input  logic [11:0] csr_addr_i,
    input  logic [1:0]  priv_i,
    input  logic        virt_i,
    input  logic        xlen32_i,
    input  logic [31:0] avail_mask_i,
    input  logic [31:0] men_i,
    input  logic [31:0] hen_i,
    input  logic [31:0] sen_i,
    output logic [1:0]  verdict_o
);
    ctr_sel_t sel;
    logic     avail_pass;
    en_bits_t en_bits;
    verdict_e priv_verdict;
    verdict_e final_verdict;

    ctr_addr_decode u_dec (
        .addr_i   (csr_addr_i),
        .xlen32_i (xlen32_i),
        .sel_o    (sel)
    );

    ctr_avail_gate u_avail (
        .sel_i        (sel),
        .avail_mask_i (avail_mask_i),
        .pass_o       (avail_pass)
    );

    always_comb begin
        en_bits.m = men_i[sel.idx];
        en_bits.h = hen_i[sel.idx];
        en_bits.s = sen_i[sel.idx];
    end

    ctr_priv_gate u_priv (
        .priv_i    (priv_e'(priv_i)),
        .virt_i    (virt_i),
        .en_i      (en_bits),
        .verdict_o (priv_verdict)
    );

    // A failed mask or decode check outranks any privilege outcome.
    always_comb begin
        final_verdict = avail_pass ? priv_verdict : VERD_ILLEGAL;
        verdict_o     = final_verdict;
    end

    always_comb begin
        // R5
        if (priv_i == PRV_MACH && avail_pass)
            mach_allow_chk: assert (verdict_o == VERD_ALLOW)
                else $error("machine read not allowed");
        // R4
        if (sel.hit && !sel.fixed && !avail_mask_i[sel.idx])
            avail_miss_chk: assert (verdict_o == VERD_ILLEGAL)
                else $error("unimplemented counter not trapped");
        // R2
        if (!xlen32_i && in_window(csr_addr_i, HI_BASE, HI_END))
            high_half_chk: assert (verdict_o == VERD_ILLEGAL)
                else $error("upper half reachable in 64-bit mode");
        // R8
        if (verdict_o == VERD_VIRTUAL)
            virt_cause_chk: assert (virt_i && men_i[sel.idx] && avail_pass)
                else $error("virtual fault without its preconditions");
        // R10
        verdict_enc_chk: assert (verdict_o != 2'b11)
            else $error("reserved verdict code");
        // R6
        if (priv_i == PRV_SUPER && !virt_i && sel.hit && !men_i[sel.idx])
            super_men_chk: assert (verdict_o == VERD_ILLEGAL)
                else $error("supervisor read passed with machine enable clear");
    end
endmodule

// File: tb/ctr_perm_chk_tb.sv
module ctr_perm_chk_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] addr;
    logic [1:0]  priv;
    logic        virt, x32;
    logic [31:0] avail, men, hen, sen;
    logic [1:0]  verdict;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ctr_perm_chk u_dut (
        .csr_addr_i   (addr),
        .priv_i       (priv),
        .virt_i       (virt),
        .xlen32_i     (x32),
        .avail_mask_i (avail),
        .men_i        (men),
        .hen_i        (hen),
        .sen_i        (sen),
        .verdict_o    (verdict)
    );

    localparam logic [1:0] A = 2'b00, IL = 2'b01, VI = 2'b10;

    function automatic int idx_of(logic [11:0] a);
        if (a >= 12'hC00 && a < 12'hC20) return int'(a - 12'hC00);
        if (a >= 12'hC80 && a < 12'hCA0) return int'(a - 12'hC80);
        return -1;
    endfunction

    function automatic logic [1:0] model(logic [11:0] a, logic [1:0] p, logic v,
                                         logic w, logic [31:0] av, logic [31:0] m,
                                         logic [31:0] h, logic [31:0] s);
        int i;
        i = idx_of(a);
        if (i < 0) return IL;
        if (a >= 12'hC80 && !w) return IL;
        if (i >= 3 && !av[i]) return IL;
        case (p)
            2'b11: return A;
            2'b01: begin
                if (!m[i]) return IL;
                if (v && !h[i]) return VI;
                return A;
            end
            2'b00: begin
                if (!v) return (m[i] && s[i]) ? A : IL;
                if (!m[i]) return IL;
                if (!h[i] || !s[i]) return VI;
                return A;
            end
            default: return IL;
        endcase
    endfunction

    function automatic string tag_of(logic [11:0] a, logic [1:0] p, logic v,
                                     logic w, logic [31:0] av);
        int i;
        i = idx_of(a);
        if (i < 0 || (a >= 12'hC80 && !w)) return "R2";
        if (i >= 3 && !av[i]) return "R4";
        if (p == 2'b10) return "R10";
        if (p == 2'b11) return (i < 3) ? "R3" : "R5";
        if (p == 2'b01) return v ? "R8" : "R6";
        return v ? "R9" : "R7";
    endfunction

    task automatic check(string req, logic [1:0] exp);
        n_chk++;
        if (verdict !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h priv=%b virt=%b x32=%b actual=%b expected=%b",
                     req, addr, priv, virt, x32, verdict, exp);
        end
    endtask

    task automatic drive(logic [11:0] a, logic [1:0] p, logic v, logic w,
                         logic [31:0] av, logic [31:0] m, logic [31:0] h,
                         logic [31:0] s);
        @(posedge clk);
        #1;
        addr = a; priv = p; virt = v; x32 = w;
        avail = av; men = m; hen = h; sen = s;
        @(negedge clk);
    endtask

    task automatic run_model(string forced_tag);
        string t;
        t = (forced_tag.len() != 0) ? forced_tag
                                    : tag_of(addr, priv, virt, x32, avail);
        check(t, model(addr, priv, virt, x32, avail, men, hen, sen));
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_bad++;
                n_chk++;
                $display("FAIL watchdog expired");
                $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [1:0] lo_v;
        void'($urandom(32'd9127));
        addr = '0; priv = '0; virt = 0; x32 = 0;
        avail = '0; men = '0; hen = '0; sen = '0;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2", IL); // idle inputs: address 0 lies outside the window

        // R3: fixed counters with empty mask, machine mode
        drive(12'hC00, 2'b11, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0); run_model("R3");
        drive(12'hC02, 2'b11, 0, 0, 32'h0, 32'h0, 32'h0, 32'h0); run_model("R3");
        // R4: event counter with empty mask, machine mode
        drive(12'hC03, 2'b11, 0, 0, 32'h0, '1, '1, '1); run_model("R4");
        drive(12'hC1F, 2'b11, 0, 0, 32'h7FFF_FFFF, '1, '1, '1); run_model("R4");
        // R2: upper half in 64-bit mode, gaps around windows
        drive(12'hC81, 2'b11, 0, 0, '1, '1, '1, '1); run_model("R2");
        drive(12'hC20, 2'b11, 0, 1, '1, '1, '1, '1); run_model("R2");
        drive(12'hCA0, 2'b11, 0, 1, '1, '1, '1, '1); run_model("R2");
        drive(12'hBFF, 2'b11, 0, 1, '1, '1, '1, '1); run_model("R2");
        // R1: upper half matches lower half in 32-bit mode
        for (int k = 0; k < 32; k++) begin
            logic [31:0] m, h, s, av;
            logic [1:0] p;
            logic v;
            m = $urandom; h = $urandom; s = $urandom; av = $urandom;
            p = 2'(($urandom % 3 == 2) ? 3 : $urandom % 2);
            v = (p != 2'b11) && $urandom % 2 == 1;
            drive(12'hC00 + 12'(k), p, v, 1, av, m, h, s);
            lo_v = verdict;
            run_model("R1");
            drive(12'hC80 + 12'(k), p, v, 1, av, m, h, s);
            check("R1", lo_v);
        end
        // R5: machine ignores enables and virt
        drive(12'hC05, 2'b11, 1, 0, 32'h20, 32'h0, 32'h0, 32'h0); run_model("R5");
        // R6
        drive(12'hC04, 2'b01, 0, 0, '1, 32'h0, '1, '1); run_model("R6");
        drive(12'hC04, 2'b01, 0, 0, '1, 32'h10, 32'h0, 32'h0); run_model("R6");
        // R7
        drive(12'hC01, 2'b00, 0, 0, '1, 32'h2, '1, 32'h0); run_model("R7");
        drive(12'hC01, 2'b00, 0, 0, '1, 32'h2, 32'h0, 32'h2); run_model("R7");
        // R8
        drive(12'hC07, 2'b01, 1, 0, '1, 32'h80, 32'h0, 32'h0); run_model("R8");
        drive(12'hC07, 2'b01, 1, 0, '1, 32'h0, 32'h0, '1); run_model("R8");
        drive(12'hC07, 2'b01, 1, 0, '1, 32'h80, 32'h80, 32'h0); run_model("R8");
        // R9
        drive(12'hC09, 2'b00, 1, 0, '1, 32'h200, 32'h200, 32'h0); run_model("R9");
        drive(12'hC09, 2'b00, 1, 0, '1, 32'h200, 32'h0, 32'h200); run_model("R9");
        drive(12'hC09, 2'b00, 1, 0, '1, 32'h200, 32'h200, 32'h200); run_model("R9");
        drive(12'hC09, 2'b00, 1, 0, '1, 32'h0, 32'h0, 32'h0); run_model("R9");
        // R10: mask miss outranks virtual condition; reserved privilege
        drive(12'hC0A, 2'b01, 1, 0, 32'h0, '1, 32'h0, '1); run_model("R10");
        drive(12'hC00, 2'b10, 0, 0, '1, '1, '1, '1); run_model("R10");

        for (int n = 0; n < 3000; n++) begin
            logic [11:0] a;
            logic [1:0] p;
            int r;
            r = $urandom % 10;
            if (r < 5)      a = 12'hC00 + 12'($urandom % 32);
            else if (r < 8) a = 12'hC80 + 12'($urandom % 32);
            else            a = 12'hBF8 + 12'($urandom % 176);
            p = 2'($urandom);
            drive(a, p, 1'($urandom), 1'($urandom),
                  $urandom | $urandom, $urandom | $urandom,
                  $urandom | $urandom, $urandom | $urandom);
            run_model("");
            if (verdict == 2'b11) begin
                n_chk++; n_bad++;
                $display("FAIL R10 actual=%b expected=not 11", verdict);
            end
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule